// File: doc/BRIEF.md
# Vector Operand Row Fetch Sequencer

This block sits in one lane of a vector unit. It takes one operand request at a time from the lane's instruction sequencer and turns it into a burst of register-file row reads. A request gives an element count, an architectural start element, the data element width, the operand element width, a rescale flag, an operand kind (data, index or bit-packed mask), a slide-up flag with its stride, and the base row of the operand register. From these the block computes the first row and the number of rows. It then issues one row address per cycle under a valid/ready handshake and marks the final row.

Data and index operands are sized in bytes: each lane row holds 8 bytes, so one row step covers `8 × NR_LANES` architectural bytes. Mask operands are bit-packed, with `NR_LANES × 64` mask bits in each row. Their start is therefore always counted in whole mask rows, never in elements. Index operands carry a count that already refers to index elements, so they are never rescaled.

Top module: `opfetch_reqgen`

## Requirements
- R1: The `req_kind` encoding is 0 for data, 1 for index, 2 for mask, and 3 behaves as data. Width codes 0, 1, 2 and 3 mean 8, 16, 32 and 64 bits. For a data operand with `req_rescale`=1, the element count is `(req_vl << req_sew) >> req_eew`. With `req_rescale`=0 the count is `req_vl`.
- R2: For an index operand (kind 1), `req_rescale` has no effect. The count is always `req_vl`.
- R3: For a data or index operand, the first row is `(req_vstart << req_eew) / (8·NR_LANES)`, rounded down.
- R4: For a data or index operand with count n, the row count is `ceil(((n − req_vstart) << req_eew) / (8·NR_LANES))`. When `req_vstart ≥ n`, the row count is 0.
- R5: For a mask operand, the first row is `req_vstart / (64·NR_LANES)`. The row count is `ceil(req_vl / (64·NR_LANES))` minus the first row, and never goes below 0. The width codes and the rescale flag have no effect on a mask operand.
- R6: When `req_slide`=1 on a mask operand, the first row also advances by `req_stride / (64·NR_LANES)` whole rows. For any other kind, the stride and the slide flag have no effect.
- R7: Read k of a stream (counting from 0) presents `rd_row = req_base + first row + k`, modulo 2^ROW_W. The index advances only on a cycle with `rd_valid` and `rd_ready` both high. Under backpressure, `rd_row` holds.
- R8: `rd_last` is high exactly on the final row. `rd_valid` is low in the cycle after the final row is accepted.
- R9: `req_ready` is high only while no stream is in progress. A request with zero rows completes without `rd_valid` going high, and the block is ready again in the next cycle.
- R10: After reset, `rd_valid` is low and `req_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Operand request present |
| req_ready | output | 1 | Block idle, request accepted |
| req_vl | input | VL_W | Element count (mask: bit count) |
| req_vstart | input | VL_W | Architectural start element |
| req_sew | input | 2 | Data element width code |
| req_eew | input | 2 | Operand element width code |
| req_rescale | input | 1 | Rescale count by width ratio |
| req_kind | input | 2 | Operand kind |
| req_slide | input | 1 | Masked slide-up: skip stride rows |
| req_stride | input | VL_W | Slide-up stride in elements |
| req_base | input | ROW_W | Operand base row |
| rd_valid | output | 1 | Row read request valid |
| rd_ready | input | 1 | Register file accepts row read |
| rd_row | output | ROW_W | Row address |
| rd_last | output | 1 | Final row of the stream |

## Verification
The assertions assume that the request fields are meaningful only in the cycle a request is accepted. They also assume that `rd_ready` may follow any pattern, including long stalls in the middle of a stream. The stimulus therefore raises `req_valid` for a single cycle, and only when `req_ready` is already high. Alongside the directed and pseudo-random requests, it drives `rd_ready` either constantly high or in a pseudo-random on/off pattern. The stimulus never uses kind 3, although the block treats that code as data.

// File: rtl/ofr_pkg.sv
package ofr_pkg;

    typedef enum logic [1:0] {
        OP_DATA  = 2'd0,
        OP_INDEX = 2'd1,
        OP_MASK  = 2'd2,
        OP_RSVD  = 2'd3
    } op_kind_e;

    // Bits held by one lane slice of a register-file row.
    localparam int unsigned SLICE_BITS  = 64;
    localparam int unsigned SLICE_BYTES = SLICE_BITS / 8;

endpackage

// File: rtl/ofr_data_span.sv
// First row and row count for data and index operands, sized in bytes.
module ofr_data_span #(
    parameter int unsigned NR_LANES = 4,
    parameter int unsigned VL_W     = 16,
    parameter int unsigned CNT_W    = 22
) (
    input  logic [VL_W-1:0]  vl,
    input  logic [VL_W-1:0]  vstart,
    input  logic [1:0]       sew,
    input  logic [1:0]       eew,
    input  logic             rescale,
    output logic [CNT_W-1:0] start_row,
    output logic [CNT_W-1:0] row_cnt
);
    localparam int unsigned ROW_BYTES = ofr_pkg::SLICE_BYTES * NR_LANES;
    localparam int unsigned ROW_SH    = $clog2(ROW_BYTES);
    localparam logic [CNT_W-1:0] ROUND_UP = CNT_W'(ROW_BYTES - 1);

    logic [CNT_W-1:0] vl_ext;
    logic [CNT_W-1:0] vs_ext;
    logic [CNT_W-1:0] n_elems;
    logic [CNT_W-1:0] skip_bytes;
    logic [CNT_W-1:0] left_bytes;

    always_comb begin
        vl_ext     = CNT_W'(vl);
        vs_ext     = CNT_W'(vstart);
        // The width ratio is applied only on request.
        n_elems    = rescale ? ((vl_ext << sew) >> eew) : vl_ext;
        skip_bytes = vs_ext << eew;
        start_row  = skip_bytes >> ROW_SH;
        left_bytes = '0;
        row_cnt    = '0;
        if (vs_ext < n_elems) begin
            left_bytes = (n_elems - vs_ext) << eew;
            row_cnt    = (left_bytes + ROUND_UP) >> ROW_SH;
        end
    end
endmodule

// File: rtl/ofr_mask_span.sv
// First row and row count for a bit-packed mask operand, in whole mask rows.
module ofr_mask_span #(
    parameter int unsigned NR_LANES = 4,
    parameter int unsigned VL_W     = 16,
    parameter int unsigned CNT_W    = 22
) (
    input  logic [VL_W-1:0]  vl,
    input  logic [VL_W-1:0]  vstart,
    input  logic             slide,
    input  logic [VL_W-1:0]  stride,
    output logic [CNT_W-1:0] start_row,
    output logic [CNT_W-1:0] row_cnt
);
    localparam int unsigned ROW_BITS = ofr_pkg::SLICE_BITS * NR_LANES;
    localparam int unsigned ROW_SH   = $clog2(ROW_BITS);
    localparam logic [CNT_W-1:0] ROUND_UP = CNT_W'(ROW_BITS - 1);

    logic [CNT_W-1:0] base_skip;
    logic [CNT_W-1:0] slide_skip;
    logic [CNT_W-1:0] total_rows;

    always_comb begin
        // Division by the row size is a shift by its logarithm.
        base_skip  = CNT_W'(vstart) >> ROW_SH;
        slide_skip = slide ? (CNT_W'(stride) >> ROW_SH) : '0;
        start_row  = base_skip + slide_skip;
        total_rows = (CNT_W'(vl) + ROUND_UP) >> ROW_SH;
        row_cnt    = (total_rows > start_row) ? (total_rows - start_row) : '0;
    end
endmodule

// File: rtl/ofr_stream.sv
// Walks the planned rows one per handshake.
module ofr_stream #(
    parameter int unsigned ROW_W = 10,
    parameter int unsigned CNT_W = 22
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [ROW_W-1:0] base_row,
    input  logic [CNT_W-1:0] first_row,
    input  logic [CNT_W-1:0] num_rows,
    output logic             idle,
    output logic             rd_valid,
    input  logic             rd_ready,
    output logic [ROW_W-1:0] rd_row,
    output logic             rd_last
);
    typedef struct packed {
        logic             busy;
        logic [ROW_W-1:0] base;
        logic [CNT_W-1:0] first;
        logic [CNT_W-1:0] total;
        logic [CNT_W-1:0] idx;
    } walk_t;

    walk_t walk_d, walk_q;
    logic [CNT_W-1:0] row_sum;
    logic             at_end;

    always_comb begin
        walk_d  = walk_q;
        at_end  = (walk_q.idx == walk_q.total - CNT_W'(1));
        row_sum = CNT_W'(walk_q.base) + walk_q.first + walk_q.idx;
        if (!walk_q.busy) begin
            if (load) begin
                walk_d.busy  = (num_rows != '0);
                walk_d.base  = base_row;
                walk_d.first = first_row;
                walk_d.total = num_rows;
                walk_d.idx   = '0;
            end
        end else if (rd_ready) begin
            if (at_end) begin
                walk_d.busy = 1'b0;
            end else begin
                walk_d.idx = walk_q.idx + CNT_W'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            walk_q <= '0;
        end else begin
            walk_q <= walk_d;
        end
    end

    assign idle     = !walk_q.busy;
    assign rd_valid = walk_q.busy;
    assign rd_row   = row_sum[ROW_W-1:0];
    assign rd_last  = walk_q.busy && at_end;

    // R7: a stalled read keeps its address
    p_hold_row_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_valid && !rd_ready) |=> (rd_valid && $stable(rd_row)));

    // R7: consecutive accepted reads step by one row
    p_row_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_valid && rd_ready && !rd_last) |=>
            (rd_valid && (rd_row == ROW_W'($past(rd_row) + ROW_W'(1)))));

    // R8: the stream ends right after its last row is taken
    p_drop_after_last_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_valid && rd_ready && rd_last) |=> !rd_valid);

    // R9: no new request while reads are outstanding
    p_busy_blocks_r9: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> !idle);
endmodule

// File: rtl/opfetch_reqgen.sv
module opfetch_reqgen #(
    parameter int unsigned NR_LANES = 4,
    parameter int unsigned VL_W     = 16,
    parameter int unsigned ROW_W    = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    output logic             req_ready,
    input  logic [VL_W-1:0]  req_vl,
    input  logic [VL_W-1:0]  req_vstart,
    input  logic [1:0]       req_sew,
    input  logic [1:0]       req_eew,
    input  logic             req_rescale,
    input  logic [1:0]       req_kind,
    input  logic             req_slide,
    input  logic [VL_W-1:0]  req_stride,
    input  logic [ROW_W-1:0] req_base,
    output logic             rd_valid,
    input  logic             rd_ready,
    output logic [ROW_W-1:0] rd_row,
    output logic             rd_last
);
    import ofr_pkg::*;

    localparam int unsigned CNT_W   = VL_W + 6;
    localparam int unsigned MROW_SH = $clog2(SLICE_BITS * NR_LANES);

    op_kind_e         kind;
    logic             eff_rescale;
    logic             idle;
    logic [CNT_W-1:0] d_start, d_cnt, m_start, m_cnt;
    logic [CNT_W-1:0] sel_start, sel_cnt;

    always_comb begin
        kind        = op_kind_e'(req_kind);
        // Index counts are already in index elements.
        eff_rescale = req_rescale && (kind != OP_INDEX);
        if (kind == OP_MASK) begin
            sel_start = m_start;
            sel_cnt   = m_cnt;
        end else begin
            sel_start = d_start;
            sel_cnt   = d_cnt;
        end
    end

    ofr_data_span #(.NR_LANES(NR_LANES), .VL_W(VL_W), .CNT_W(CNT_W)) data_span_i (
        .vl(req_vl), .vstart(req_vstart), .sew(req_sew), .eew(req_eew),
        .rescale(eff_rescale), .start_row(d_start), .row_cnt(d_cnt)
    );

    ofr_mask_span #(.NR_LANES(NR_LANES), .VL_W(VL_W), .CNT_W(CNT_W)) mask_span_i (
        .vl(req_vl), .vstart(req_vstart), .slide(req_slide), .stride(req_stride),
        .start_row(m_start), .row_cnt(m_cnt)
    );

    ofr_stream #(.ROW_W(ROW_W), .CNT_W(CNT_W)) stream_i (
        .clk(clk), .rst_n(rst_n), .load(req_valid),
        .base_row(req_base), .first_row(sel_start), .num_rows(sel_cnt),
        .idle(idle), .rd_valid(rd_valid), .rd_ready(rd_ready),
        .rd_row(rd_row), .rd_last(rd_last)
    );

    assign req_ready = idle;

    // R5 R6: the first mask read lands on the whole-row offset
    p_mask_first_row_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && (req_kind == 2'd2)) |=>
            (!rd_valid || (rd_row == ROW_W'($past(req_base)
                + ROW_W'(CNT_W'($past(req_vstart)) >> MROW_SH)
                + ROW_W'($past(req_slide) ? (CNT_W'($past(req_stride)) >> MROW_SH) : '0)))));

    // R9: an accepted request always leaves the idle state or stays quiet
    p_accept_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> (rd_valid != req_ready));
endmodule

// File: tb/opfetch_reqgen_tb.sv
module opfetch_reqgen_tb_top;
    localparam int NL    = 4;
    localparam int VL_W  = 16;
    localparam int ROW_W = 10;

    typedef struct {
        logic [ROW_W-1:0] row;
        bit               last;
        string            tag;
    } exp_t;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             req_valid = 1'b0;
    logic             req_ready;
    logic [VL_W-1:0]  req_vl = '0, req_vstart = '0, req_stride = '0;
    logic [1:0]       req_sew = '0, req_eew = '0, req_kind = '0;
    logic             req_rescale = 1'b0, req_slide = 1'b0;
    logic [ROW_W-1:0] req_base = '0;
    logic             rd_valid, rd_ready = 1'b0, rd_last;
    logic [ROW_W-1:0] rd_row;

    int   n_checks = 0;
    int   n_fails  = 0;
    int   ready_mode = 0;
    logic [15:0] lfsr = 16'hACE1;
    exp_t sb_q[$];
    bit   done = 0;

    always #2 clk = ~clk;

    opfetch_reqgen #(.NR_LANES(NL), .VL_W(VL_W), .ROW_W(ROW_W)) dut_i (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_vl(req_vl), .req_vstart(req_vstart), .req_sew(req_sew), .req_eew(req_eew),
        .req_rescale(req_rescale), .req_kind(req_kind), .req_slide(req_slide),
        .req_stride(req_stride), .req_base(req_base), .rd_valid(rd_valid),
        .rd_ready(rd_ready), .rd_row(rd_row), .rd_last(rd_last)
    );

    function automatic void plan(input int kind, input int vl, input int vs, input int sew,
                                 input int eew, input bit resc, input bit slide, input int stride,
                                 output int first, output int cnt);
        int n, tot;
        if (kind == 2) begin
            first = vs / (64 * NL) + (slide ? stride / (64 * NL) : 0);
            tot   = (vl + 64 * NL - 1) / (64 * NL);
            cnt   = (tot > first) ? tot - first : 0;
        end else begin
            n     = (resc && kind != 1) ? ((vl * (1 << sew)) / (1 << eew)) : vl;
            first = (vs * (1 << eew)) / (8 * NL);
            cnt   = (vs >= n) ? 0 : (((n - vs) * (1 << eew)) + 8 * NL - 1) / (8 * NL);
        end
    endfunction

    task automatic check(input bit ok, input string msg);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s", msg);
        end
    endtask

    task automatic send(input string tag, input int kind, input int vl, input int vs,
                        input int sew, input int eew, input bit resc, input bit slide,
                        input int stride, input int base);
        int   first, cnt;
        exp_t e;
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        plan(kind, vl, vs, sew, eew, resc, slide, stride, first, cnt);
        for (int k = 0; k < cnt; k++) begin
            e.row  = ROW_W'(base + first + k);
            e.last = (k == cnt - 1);
            e.tag  = tag;
            sb_q.push_back(e);
        end
        req_kind = 2'(kind); req_vl = VL_W'(vl); req_vstart = VL_W'(vs);
        req_sew = 2'(sew); req_eew = 2'(eew); req_rescale = resc;
        req_slide = slide; req_stride = VL_W'(stride); req_base = ROW_W'(base);
        req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        if (cnt == 0)
            check(!rd_valid && req_ready,
                  $sformatf("%s R9 zero rows: valid=%0b ready=%0b expected valid=0 ready=1",
                            tag, rd_valid, req_ready));
    endtask

    // Scoreboard monitor: drives rd_ready, compares every accepted row.
    always @(negedge clk) begin
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        rd_ready = (ready_mode == 0) ? 1'b1 : lfsr[0];
        if (rst_n && rd_valid && rd_ready) begin
            if (sb_q.size() == 0) begin
                check(1'b0, $sformatf("R9 unexpected row %0d, expected none", rd_row));
            end else begin
                exp_t e;
                e = sb_q.pop_front();
                check(rd_row == e.row, $sformatf("%s R7 row: actual %0d expected %0d",
                                                 e.tag, rd_row, e.row));
                check(rd_last == e.last, $sformatf("%s R8 last: actual %0b expected %0b",
                                                   e.tag, rd_last, e.last));
            end
        end
    end

    task automatic drain;
        @(negedge clk);
        while (!(req_ready && sb_q.size() == 0)) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(!rd_valid && req_ready, $sformatf("R10 reset: valid=%0b ready=%0b expected 0 1",
                                                rd_valid, req_ready));
        for (int pass = 0; pass < 2; pass++) begin
            ready_mode = pass;
            send("R1", 0, 64, 0, 0, 0, 1, 0, 0, 5);
            send("R1", 0, 64, 0, 0, 1, 1, 0, 0, 9);
            send("R1", 0, 64, 0, 0, 1, 0, 0, 0, 20);
            send("R2", 1, 64, 0, 0, 1, 1, 0, 0, 40);
            send("R2", 1, 16, 0, 2, 0, 1, 0, 0, 40);
            send("R3", 0, 40, 10, 2, 2, 0, 0, 0, 100);
            send("R4", 0, 40, 40, 2, 2, 0, 0, 0, 3);
            send("R4", 0, 10, 12, 0, 0, 0, 0, 0, 3);
            send("R5", 2, 300, 0, 0, 3, 1, 0, 0, 60);
            send("R5", 2, 300, 260, 1, 0, 1, 0, 0, 60);
            send("R5", 2, 6, 5, 1, 1, 0, 0, 0, 61);
            send("R5", 2, 300, 600, 0, 3, 0, 0, 0, 62);
            send("R6", 2, 300, 0, 0, 3, 0, 1, 256, 70);
            send("R6", 2, 1100, 4, 0, 3, 0, 1, 600, 70);
            send("R6", 0, 64, 0, 0, 0, 0, 1, 512, 80);
            send("R7", 0, 64, 0, 3, 3, 0, 0, 0, 1020);
            drain();
        end
        ready_mode = 1;
        for (int i = 0; i < 20; i++) begin
            send("R1", int'($urandom_range(2, 0)), int'($urandom_range(255, 0)),
                 int'($urandom_range(80, 0)), int'($urandom_range(3, 0)),
                 int'($urandom_range(3, 0)), 1'($urandom_range(1, 0)),
                 1'($urandom_range(1, 0)), int'($urandom_range(600, 0)),
                 int'($urandom_range(1023, 0)));
        end
        drain();
        check(sb_q.size() == 0, $sformatf("R8 leftover rows: actual %0d expected 0", sb_q.size()));
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fails++;
            $display("FAIL R9 watchdog: actual hung expected finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    end
endmodule